// File: doc/BRIEF.md
# Two-Tier Maskable Interrupt Controller

This block collects interrupt events for a small 8-bit processor core and turns them into a single request line. There are ten sources. Three are core sources: an external pin edge, a change on the upper port bits, and a timer overflow. The other seven are peripheral event strobes. Each source has a sticky flag and its own enable. Peripheral sources also pass a shared peripheral group enable. Every source then passes one global enable. Flags latch whenever their event occurs, whatever the state of any mask.

The core reads and writes the flag, enable and configuration registers through a simple synchronous port. When the core takes the interrupt it pulses an acknowledge. The controller then clears the global enable and presents a fixed vector address of 0x0004. A return strobe sets the global enable again. Flags are only cleared by software. A separate wake output follows the enabled sources ahead of the global gate, so an enabled event can bring the core out of sleep while interrupts are globally off.

Top module: `irqc_top`

## Requirements
- R1: After a synchronous reset the global enable, the peripheral group enable, all enables, all flags, the edge select, `irq_req` and `wake` are all 0.
- R2: A flag is set by its event in the same clock edge as the event, whatever the state of its enable, the group enable or the global enable. The hardware never clears a flag; only a register write can clear it.
- R3: Register map by `addr`:
  - 0 is the main register: bit7 global enable, bit6 peripheral group enable, bit5 timer enable, bit4 pin enable, bit3 port-change enable, bit2 timer flag, bit1 pin flag, bit0 port-change flag.
  - 1 holds peripheral flags 0..3 in bits 3:0, and 2 holds peripheral flags 4..6 in bits 2:0.
  - 3 and 4 hold the matching peripheral enables.
  - 5 bit0 is the pin edge select.
  - Unused bits read 0. `rd_data` shows the register selected by `addr` one clock later.
- R4: `irq_req` is high one clock after the global enable is set and at least one source has both its flag and its enable set. A peripheral source also needs the group enable.
- R5: An `irq_ack` pulse clears the global enable at that edge, so `irq_req` falls one clock later. All flags keep their values.
- R6: An `irq_ret` pulse without `irq_ack` sets the global enable. A flag still set and enabled raises `irq_req` again one clock later.
- R7: `wake` is high one clock after any enabled core source, or any enabled peripheral source with the group enable set, is pending. This holds whatever the global enable is.
- R8: `ext_pin` passes two synchronizer flops and an edge detector. With edge select 0 only a rising edge sets the pin flag, and with edge select 1 only a falling edge does. The flag is set on the third rising clock edge after the pin changes.
- R9: The port-change flag is set when the synchronized `port_hi` value differs from the value latched on the previous clock. An unchanging port sets nothing.
- R10: When a write that clears a flag falls on the same edge as that flag's event, the flag ends up set.
- R11: `vec_addr` is always 0x0004.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_pin | input | 1 | Asynchronous external interrupt pin |
| port_hi | input | 4 | Monitored upper port bits (asynchronous) |
| tmr_ovf | input | 1 | Timer overflow strobe, one clock |
| per_evt | input | 7 | Peripheral event strobes, one clock each |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |
| irq_ack | input | 1 | Core accepts the interrupt |
| irq_ret | input | 1 | Return-from-interrupt strobe |
| irq_req | output | 1 | Registered interrupt request |
| vec_addr | output | 13 | Fixed interrupt vector |
| wake | output | 1 | Registered wake-from-sleep request |

## Verification
The assertions assume several things about the inputs:
- `tmr_ovf` and `per_evt` are synchronous pulses.
- `irq_ack` and `irq_ret` are never high in the same cycle as a write to the main register.
- Reset is held for at least one edge before any check counts.

The stimulus meets these assumptions in three ways:
- Every input is driven only at falling clock edges.
- Strobes last exactly one cycle.
- Acknowledge, return and register writes are issued from separate task steps, so they never overlap.

The asynchronous pin and port inputs also change only at falling edges. This makes the synchronizer latency exact and lets the bench check the edge-to-flag cycle count.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int DW = 8;
  localparam int AW = 3;

  typedef enum logic [AW-1:0] {
    A_MAIN = 3'd0,
    A_PFLO = 3'd1,
    A_PFHI = 3'd2,
    A_PELO = 3'd3,
    A_PEHI = 3'd4,
    A_CFG  = 3'd5
  } reg_addr_e;

  // main register bit positions
  localparam int B_GE  = 7;
  localparam int B_PE  = 6;
  localparam int B_EN0 = 3;  // enables occupy B_EN0 .. B_EN0+2
  localparam int B_FL0 = 0;  // flags occupy B_FL0 .. B_FL0+2
  localparam int NCORE = 3;  // 0 port change, 1 pin, 2 timer
endpackage

// File: rtl/irqc_pin_edge.sv
module irqc_pin_edge (
  input  logic clk,
  input  logic rst,
  input  logic pin_i,
  input  logic fall_sel_i,
  output logic edge_o
);
  logic s1_q, s2_q, s3_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      s3_q <= 1'b0;
    end else begin
      s1_q <= pin_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  always_comb begin
    if (fall_sel_i) edge_o = s3_q & ~s2_q;
    else            edge_o = s2_q & ~s3_q;
  end

  // R8
  edge_single_chk: assert property (@(posedge clk) disable iff (rst)
    (edge_o && !fall_sel_i) |=> !(edge_o && !fall_sel_i));
endmodule

// File: rtl/irqc_port_chg.sv
module irqc_port_chg #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] port_i,
  output logic         chg_o
);
  logic [W-1:0] sync_q, last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      last_q <= '0;
    end else begin
      sync_q <= port_i;
      last_q <= sync_q;
    end
  end

  assign chg_o = (sync_q != last_q);

  // R9
  chg_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (chg_o && $stable(port_i)) |=> !chg_o);
endmodule

// File: rtl/irqc_flag_bank.sv
module irqc_flag_bank #(
  parameter int N = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] evt_i,
  input  logic [N-1:0] wr_i,
  input  logic [N-1:0] wdata_i,
  output logic [N-1:0] flag_o
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst) flag_o[i] <= 1'b0;
      else     flag_o[i] <= (wr_i[i] ? wdata_i[i] : flag_o[i]) | evt_i[i];
    end

    // R2
    flag_set_chk: assert property (@(posedge clk) disable iff (rst)
      evt_i[i] |=> flag_o[i]);
    // R10
    flag_race_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_i[i] && !wdata_i[i] && evt_i[i]) |=> flag_o[i]);
    // R2
    flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (flag_o[i] && !wr_i[i]) |=> flag_o[i]);
  end
endmodule

// File: rtl/irqc_top.sv
module irqc_top
  import irqc_pkg::*;
#(
  parameter int              PORT_W = 4,
  parameter int              NPER   = 7,
  parameter int              PLO    = 4,
  parameter int              VEC_W  = 13,
  parameter logic [VEC_W-1:0] VEC   = 13'h0004
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ext_pin,
  input  logic [PORT_W-1:0] port_hi,
  input  logic              tmr_ovf,
  input  logic [NPER-1:0]   per_evt,
  input  logic              wr_en,
  input  logic [AW-1:0]     addr,
  input  logic [DW-1:0]     wr_data,
  output logic [DW-1:0]     rd_data,
  input  logic              irq_ack,
  input  logic              irq_ret,
  output logic              irq_req,
  output logic [VEC_W-1:0]  vec_addr,
  output logic              wake
);
  localparam int PHI = NPER - PLO;

  logic wr_main, wr_pflo, wr_pfhi, wr_pelo, wr_pehi, wr_cfg;
  assign wr_main = wr_en && (addr == A_MAIN);
  assign wr_pflo = wr_en && (addr == A_PFLO);
  assign wr_pfhi = wr_en && (addr == A_PFHI);
  assign wr_pelo = wr_en && (addr == A_PELO);
  assign wr_pehi = wr_en && (addr == A_PEHI);
  assign wr_cfg  = wr_en && (addr == A_CFG);

  logic ge_q, pe_q, fall_q;
  logic [NCORE-1:0] core_en_q, core_flag;
  logic [NPER-1:0]  per_en_q, per_flag;
  logic pin_evt, chg_evt;

  irqc_pin_edge u_pin (
    .clk(clk), .rst(rst), .pin_i(ext_pin), .fall_sel_i(fall_q), .edge_o(pin_evt)
  );

  irqc_port_chg #(.W(PORT_W)) u_chg (
    .clk(clk), .rst(rst), .port_i(port_hi), .chg_o(chg_evt)
  );

  irqc_flag_bank #(.N(NCORE)) u_core_flags (
    .clk(clk), .rst(rst),
    .evt_i({tmr_ovf, pin_evt, chg_evt}),
    .wr_i({NCORE{wr_main}}),
    .wdata_i(wr_data[B_FL0 +: NCORE]),
    .flag_o(core_flag)
  );

  logic [NPER-1:0] per_wr, per_wd, per_en_wr;
  for (genvar i = 0; i < NPER; i++) begin : g_per_route
    if (i < PLO) begin : g_lo
      assign per_wr[i]    = wr_pflo;
      assign per_en_wr[i] = wr_pelo;
      assign per_wd[i]    = wr_data[i];
    end else begin : g_hi
      assign per_wr[i]    = wr_pfhi;
      assign per_en_wr[i] = wr_pehi;
      assign per_wd[i]    = wr_data[i-PLO];
    end
  end

  irqc_flag_bank #(.N(NPER)) u_per_flags (
    .clk(clk), .rst(rst),
    .evt_i(per_evt), .wr_i(per_wr), .wdata_i(per_wd), .flag_o(per_flag)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ge_q      <= 1'b0;
      pe_q      <= 1'b0;
      fall_q    <= 1'b0;
      core_en_q <= '0;
      per_en_q  <= '0;
    end else begin
      if (irq_ack)      ge_q <= 1'b0;
      else if (irq_ret) ge_q <= 1'b1;
      else if (wr_main) ge_q <= wr_data[B_GE];
      if (wr_main) begin
        pe_q      <= wr_data[B_PE];
        core_en_q <= wr_data[B_EN0 +: NCORE];
      end
      if (wr_cfg) fall_q <= wr_data[0];
      for (int i = 0; i < NPER; i++)
        if (per_en_wr[i]) per_en_q[i] <= per_wd[i];
    end
  end

  logic core_pend, per_pend, wake_c;
  assign core_pend = |(core_flag & core_en_q);
  assign per_pend  = |(per_flag & per_en_q);
  assign wake_c    = core_pend | (pe_q & per_pend);

  logic [DW-1:0] rd_c;
  always_comb begin
    rd_c = '0;
    case (addr)
      A_MAIN: begin
        rd_c[B_GE] = ge_q;
        rd_c[B_PE] = pe_q;
        rd_c[B_EN0 +: NCORE] = core_en_q;
        rd_c[B_FL0 +: NCORE] = core_flag;
      end
      A_PFLO: rd_c[PLO-1:0] = per_flag[PLO-1:0];
      A_PFHI: rd_c[PHI-1:0] = per_flag[NPER-1:PLO];
      A_PELO: rd_c[PLO-1:0] = per_en_q[PLO-1:0];
      A_PEHI: rd_c[PHI-1:0] = per_en_q[NPER-1:PLO];
      A_CFG:  rd_c[0] = fall_q;
      default: rd_c = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_req <= 1'b0;
      wake    <= 1'b0;
      rd_data <= '0;
    end else begin
      irq_req <= ge_q & wake_c;
      wake    <= wake_c;
      rd_data <= rd_c;
    end
  end

  assign vec_addr = VEC;

  // R4
  req_needs_ge_chk: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> $past(ge_q));
  // R7
  req_implies_wake_chk: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> wake);
  // R5
  ack_clears_ge_chk: assert property (@(posedge clk) disable iff (rst)
    irq_ack |=> !ge_q);
  // R6
  ret_sets_ge_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_ret && !irq_ack) |=> ge_q);
  // R5
  ack_keeps_flags_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_ack && !wr_en) |=> ($past(core_flag) & ~core_flag) == '0);
endmodule

// File: tb/irqc_top_tb_top.sv
`timescale 1ns/100ps
module irqc_top_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ext_pin = 1'b0;
  logic [3:0] port_hi = '0;
  logic tmr_ovf = 1'b0;
  logic [6:0] per_evt = '0;
  logic wr_en = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic irq_ack = 1'b0, irq_ret = 1'b0;
  logic irq_req, wake;
  logic [12:0] vec_addr;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  irqc_top dut_i (
    .clk(clk), .rst(rst), .ext_pin(ext_pin), .port_hi(port_hi),
    .tmr_ovf(tmr_ovf), .per_evt(per_evt), .wr_en(wr_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .irq_ack(irq_ack),
    .irq_ret(irq_ret), .irq_req(irq_req), .vec_addr(vec_addr), .wake(wake)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); addr = a;
    @(negedge clk); d = rd_data;
  endtask

  task automatic clear_all();
    for (int a = 0; a < 6; a++) wr(3'(a), 8'h00);
  endtask

  task automatic pulse_per(input int i);
    @(negedge clk); per_evt[i] = 1'b1;
    @(negedge clk); per_evt = '0;
  endtask

  task automatic pulse_tmr();
    @(negedge clk); tmr_ovf = 1'b1;
    @(negedge clk); tmr_ovf = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), d);
      check("R1 reg after reset", d, 8'h00);
    end
    check("R1 irq_req after reset", irq_req, 1'b0);
    check("R1 wake after reset", wake, 1'b0);
    check("R11 vector", vec_addr, 13'h0004);
  endtask

  task automatic t_unmasked();
    logic [7:0] d;
    pulse_tmr();
    pulse_per(0);
    pulse_per(6);
    rd(3'd0, d); check("R2 timer flag, masks off", d, 8'h04);
    rd(3'd1, d); check("R2 per flag 0, masks off", d, 8'h01);
    rd(3'd2, d); check("R3 per flag 6 in hi bit2", d, 8'h04);
    cyc(5);
    rd(3'd0, d); check("R2 flag stays set", d, 8'h04);
    check("R4 no request when masked", irq_req, 1'b0);
    clear_all();
  endtask

  task automatic t_regmap();
    logic [7:0] d;
    wr(3'd3, 8'hFF); rd(3'd3, d); check("R3 per en lo width", d, 8'h0F);
    wr(3'd4, 8'hFF); rd(3'd4, d); check("R3 per en hi width", d, 8'h07);
    wr(3'd5, 8'hFF); rd(3'd5, d); check("R3 cfg width", d, 8'h01);
    wr(3'd0, 8'h78); rd(3'd0, d); check("R3 main enables", d, 8'h78);
    wr(3'd0, 8'h07); rd(3'd0, d); check("R3 main flags writable", d, 8'h07);
    clear_all();
  endtask

  task automatic t_gating();
    pulse_per(1);
    wr(3'd3, 8'h02);
    wr(3'd0, 8'h80);
    cyc(2); check("R4 periph without group enable", irq_req, 1'b0);
    wr(3'd0, 8'hC0);
    cyc(1); check("R4 periph with group enable", irq_req, 1'b1);
    wr(3'd0, 8'h40);
    cyc(1); check("R4 global enable off", irq_req, 1'b0);
    clear_all();
    pulse_tmr();
    wr(3'd0, 8'hA4);
    cyc(1); check("R4 core source no group enable", irq_req, 1'b1);
    clear_all();
  endtask

  task automatic t_ack_ret();
    logic [7:0] d;
    pulse_tmr();
    wr(3'd0, 8'hA4);
    cyc(1); check("R4 request before ack", irq_req, 1'b1);
    @(negedge clk); irq_ack = 1'b1;
    @(negedge clk); irq_ack = 1'b0;
    check("R5 request one edge after ack", irq_req, 1'b1);
    @(negedge clk); check("R5 request dropped", irq_req, 1'b0);
    rd(3'd0, d); check("R5 ge cleared, flag kept", d, 8'h24);
    @(negedge clk); irq_ret = 1'b1;
    @(negedge clk); irq_ret = 1'b0;
    @(negedge clk); check("R6 pending flag retriggers", irq_req, 1'b1);
    rd(3'd0, d); check("R6 ge set by return", d, 8'hA4);
    wr(3'd0, 8'hA0);
    cyc(1); check("R6 cleared flag, no request", irq_req, 1'b0);
    clear_all();
  endtask

  task automatic t_wake();
    pulse_per(5);
    wr(3'd4, 8'h02);
    cyc(1); check("R7 no wake without group enable", wake, 1'b0);
    wr(3'd0, 8'h40);
    cyc(1); check("R7 wake with ge clear", wake, 1'b1);
    check("R7 no request with ge clear", irq_req, 1'b0);
    wr(3'd4, 8'h00);
    cyc(1); check("R7 wake falls when disabled", wake, 1'b0);
    clear_all();
  endtask

  task automatic t_pin();
    logic [7:0] d;
    @(negedge clk); addr = 3'd0;
    @(negedge clk); ext_pin = 1'b1;
    cyc(3); check("R8 rising not yet visible", rd_data[1], 1'b0);
    cyc(1); check("R8 rising flag on third edge", rd_data[1], 1'b1);
    wr(3'd0, 8'h00);
    wr(3'd5, 8'h01);
    cyc(4);
    wr(3'd0, 8'h00);
    @(negedge clk); ext_pin = 1'b0;
    cyc(6); rd(3'd0, d); check("R8 falling mode falling edge", d[1], 1'b1);
    wr(3'd0, 8'h00);
    @(negedge clk); ext_pin = 1'b1;
    cyc(6); rd(3'd0, d); check("R8 falling mode ignores rise", d[1], 1'b0);
    wr(3'd5, 8'h00);
    cyc(4);
    wr(3'd0, 8'h00);
    @(negedge clk); ext_pin = 1'b0;
    cyc(6); rd(3'd0, d); check("R8 rising mode ignores fall", d[1], 1'b0);
    clear_all();
  endtask

  task automatic t_port();
    logic [7:0] d;
    @(negedge clk); port_hi = 4'h9;
    cyc(4); rd(3'd0, d); check("R9 port change flag", d[0], 1'b1);
    wr(3'd0, 8'h00);
    cyc(6); rd(3'd0, d); check("R9 steady port no flag", d[0], 1'b0);
    clear_all();
  endtask

  task automatic t_race();
    logic [7:0] d;
    pulse_per(2);
    @(negedge clk); wr_en = 1'b1; addr = 3'd1; wr_data = 8'h00; per_evt[2] = 1'b1;
    @(negedge clk); wr_en = 1'b0; per_evt = '0;
    rd(3'd1, d); check("R10 set wins over clear", d, 8'h04);
    clear_all();
    pulse_tmr();
    @(negedge clk); wr_en = 1'b1; addr = 3'd0; wr_data = 8'h00; tmr_ovf = 1'b1;
    @(negedge clk); wr_en = 1'b0; tmr_ovf = 1'b0;
    rd(3'd0, d); check("R10 core set wins", d, 8'h04);
    clear_all();
  endtask

  initial begin
    cyc(3);
    rst = 1'b0;
    cyc(1);
    t_reset();
    t_unmasked();
    t_regmap();
    t_gating();
    t_ack_ret();
    t_wake();
    t_pin();
    t_port();
    t_race();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule